// File: doc/BRIEF.md
# Paired 10-bit Sample Byte Codec

This block carries pairs of 10-bit samples over a byte-wide link. Each pair becomes a group of three bytes. Only the first byte of a group has its most significant bit set, so a receiver that joins the stream at any point can find the next group boundary without a separate delimiter byte. One bit is left over in the third byte. Depending on the `parity_mode` input, it is either held at zero or carries even parity over the 20 data bits.

The encoder side takes a sample pair through a valid/ready handshake and sends the three bytes on consecutive cycles. It accepts the next pair while the last byte of the current group is going out, so a steady supply of pairs gives a gapless byte stream. The decoder side takes bytes qualified by `rx_valid` and drops them until a byte with its top bit set arrives. It then rebuilds both samples and checks the reserved bits and the parity. For each group it gives a one-cycle result pulse with an error flag. If a byte with its top bit set turns up in the middle of a group, the decoder flags the broken group and treats that byte as the start of a new group. The two directions are independent and share only the clock, the reset and the spare-bit mode.

Top module: `pp_codec`

## Requirements
- R1: The first byte sent for a pair (A, B) is {1, A[9:3]}. Bit 7 is the group marker.
- R2: The second byte is {0, A[2:0], B[9:6]}.
- R3: The third byte is {0, S, B[5:0]}, where S sits at bit 6. S is 0 when `parity_mode`=0. S is the XOR of all 20 bits of A and B when `parity_mode`=1.
- R4: `in_ready` is 1 when the encoder is idle or is presenting the third byte, and 0 while it presents the first or second byte. After a pair is accepted at a clock edge, the three bytes appear with `tx_valid`=1 after that edge and the next two edges. `tx_valid` then drops unless another pair was accepted.
- R5: While the decoder is looking for a group start, bytes with bit 7 clear are dropped and produce no `out_valid`.
- R6: When the decoder takes the third byte of a group, `out_valid` is 1 for one cycle after that edge, with `out_a` and `out_b` rebuilt. `out_err` is 0 when all checks pass. No `out_valid` follows the first or second byte of a group.
- R7: With `parity_mode`=0, a third byte with bit 6 set gives `out_valid`=1 with `out_err`=1.
- R8: With `parity_mode`=1, a third byte whose bit 6 differs from the XOR of the 20 data bits gives `out_valid`=1 with `out_err`=1.
- R9: A byte with bit 7 set in position two or three gives `out_valid`=1 with `out_err`=1 one cycle later. That byte is taken as the first byte of a new group.
- R10: Under reset, `in_ready`=1, `tx_valid`=0 and `out_valid`=0, and the decoder is looking for a group start.
- R11: The decoder ignores `rx_byte` while `rx_valid`=0, so idle cycles may separate the bytes of a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| parity_mode | input | 1 | Spare-bit mode: 0 for a fixed zero, 1 for even parity over the 20 data bits |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | The encoder can accept a pair |
| in_a | input | 10 | Sample A |
| in_b | input | 10 | Sample B |
| tx_valid | output | 1 | `tx_byte` holds a link byte |
| tx_byte | output | 8 | Outgoing link byte |
| rx_valid | input | 1 | `rx_byte` holds a link byte |
| rx_byte | input | 8 | Incoming link byte |
| out_valid | output | 1 | Result pulse for one group |
| out_a | output | 10 | Rebuilt sample A |
| out_b | output | 10 | Rebuilt sample B |
| out_err | output | 1 | The group failed a marker, reserved-bit or parity check |

## Verification
The encoder's first byte is due one edge after acceptance, and each later byte one edge after the previous one. The bench drives inputs on falling edges and compares `tx_byte` and `in_ready` at each of the next three falling edges, then checks one more edge to confirm that `tx_valid` has dropped. A decoder result is due on the edge that takes the third byte, or the misplaced marker byte. So the bench reads `out_valid`, `out_err` and the samples at the falling edge right after each pushed byte. That way it also confirms that no pulse follows the other bytes or the idle gaps.

// File: rtl/pp_codec_pkg.sv
package pp_codec_pkg;
  localparam int SMP_W   = 10;               // sample width
  localparam int LNK_W   = 8;                // link byte width
  localparam int HEAD_W  = LNK_W - 1;        // payload bits per byte
  localparam int ATAIL_W = SMP_W - HEAD_W;   // A bits carried in byte two
  localparam int BHEAD_W = HEAD_W - ATAIL_W; // B bits carried in byte two
  localparam int BTAIL_W = SMP_W - BHEAD_W;  // B bits carried in byte three
  localparam int SPARE_B = LNK_W - 2;        // spare bit position in byte three
  localparam int GRP_N   = 3;                // bytes per group
  localparam int IDX_W   = $clog2(GRP_N);

  typedef enum logic [1:0] {
    DEC_HUNT = 2'd0,
    DEC_GOT1 = 2'd1,
    DEC_GOT2 = 2'd2
  } dec_pos_e;
endpackage

// File: rtl/pp_rst_sync.sv
module pp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pp_encoder.sv
module pp_encoder
  import pp_codec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             parity_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_a,
  input  logic [SMP_W-1:0] in_b,
  output logic             tx_valid,
  output logic [LNK_W-1:0] tx_byte
);
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LNK_W-1:0] b0_q, b1_q, b2_q, b0_d, b1_d, b2_d;
  logic             last, load, spare;

  assign last     = busy_q && (idx_q == IDX_W'(GRP_N - 1));
  assign in_ready = !busy_q || last;
  assign load     = in_valid && in_ready;
  assign spare    = parity_mode & (^{in_a, in_b});

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    b0_d   = b0_q;
    b1_d   = b1_q;
    b2_d   = b2_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
      b0_d   = {1'b1, in_a[SMP_W-1 -: HEAD_W]};
      b1_d   = {1'b0, in_a[ATAIL_W-1:0], in_b[SMP_W-1 -: BHEAD_W]};
      b2_d   = {1'b0, spare, in_b[BTAIL_W-1:0]};
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      b0_q <= b0_d;
      b1_q <= b1_d;
      b2_q <= b2_d;
    end
  end

  always_comb begin
    case (idx_q)
      IDX_W'(0): tx_byte = b0_q;
      IDX_W'(1): tx_byte = b1_q;
      default:   tx_byte = b2_q;
    endcase
  end

  assign tx_valid = busy_q;
endmodule

// File: rtl/pp_decoder.sv
module pp_decoder
  import pp_codec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             parity_mode,
  input  logic             rx_valid,
  input  logic [LNK_W-1:0] rx_byte,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_a,
  output logic [SMP_W-1:0] out_b,
  output logic             out_err
);
  dec_pos_e          pos_q, pos_d;
  logic [HEAD_W-1:0] hi_q, hi_d, mid_q, mid_d;
  logic              ov_q, ov_d, oe_q, oe_d;
  logic [SMP_W-1:0]  a_q, a_d, b_q, b_d;
  logic              marker, sum_par;

  assign marker  = rx_byte[LNK_W-1];
  assign sum_par = ^{hi_q, mid_q, rx_byte[BTAIL_W-1:0]};

  always_comb begin
    pos_d = pos_q;
    hi_d  = hi_q;
    mid_d = mid_q;
    ov_d  = 1'b0;
    oe_d  = 1'b0;
    a_d   = a_q;
    b_d   = b_q;
    if (rx_valid) begin
      case (pos_q)
        DEC_HUNT: begin
          if (marker) begin
            hi_d  = rx_byte[HEAD_W-1:0];
            pos_d = DEC_GOT1;
          end
        end
        DEC_GOT1: begin
          if (marker) begin
            ov_d = 1'b1;
            oe_d = 1'b1;
            hi_d = rx_byte[HEAD_W-1:0];
          end else begin
            mid_d = rx_byte[HEAD_W-1:0];
            pos_d = DEC_GOT2;
          end
        end
        default: begin
          ov_d = 1'b1;
          if (marker) begin
            oe_d  = 1'b1;
            hi_d  = rx_byte[HEAD_W-1:0];
            pos_d = DEC_GOT1;
          end else begin
            a_d   = {hi_q, mid_q[HEAD_W-1 -: ATAIL_W]};
            b_d   = {mid_q[BHEAD_W-1:0], rx_byte[BTAIL_W-1:0]};
            oe_d  = parity_mode ? (rx_byte[SPARE_B] ^ sum_par) : rx_byte[SPARE_B];
            pos_d = DEC_HUNT;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= DEC_HUNT;
      ov_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      pos_q <= pos_d;
      ov_q  <= ov_d;
      oe_q  <= oe_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_valid) begin
      hi_q  <= hi_d;
      mid_q <= mid_d;
      a_q   <= a_d;
      b_q   <= b_d;
    end
  end

  assign out_valid = ov_q;
  assign out_err   = oe_q;
  assign out_a     = a_q;
  assign out_b     = b_q;
endmodule

// File: rtl/pp_codec.sv
module pp_codec
  import pp_codec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             parity_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_a,
  input  logic [SMP_W-1:0] in_b,
  output logic             tx_valid,
  output logic [LNK_W-1:0] tx_byte,
  input  logic             rx_valid,
  input  logic [LNK_W-1:0] rx_byte,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_a,
  output logic [SMP_W-1:0] out_b,
  output logic             out_err
);
  logic rst_n_s;

  pp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  pp_encoder u_enc (
    .clk(clk), .rst_n(rst_n_s), .parity_mode(parity_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  pp_decoder u_dec (
    .clk(clk), .rst_n(rst_n_s), .parity_mode(parity_mode),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_err(out_err)
  );
endmodule

// File: rtl/pp_codec_chk.sv
module pp_codec_chk
  import pp_codec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             parity_mode,
  input logic             in_valid,
  input logic             in_ready,
  input logic             tx_valid,
  input logic [LNK_W-1:0] tx_byte,
  input logic             rx_valid,
  input logic             out_valid,
  input logic             out_err
);
  a_r1_first_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tx_valid && tx_byte[LNK_W-1]));

  a_r2_second_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 (tx_valid && !tx_byte[LNK_W-1]));

  a_r3_third_spare: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##2 (tx_valid && !tx_byte[LNK_W-1] &&
      (tx_byte[SPARE_B] == ($past(parity_mode, 2) &
        (^{($past(tx_byte, 2) & 8'h7F), ($past(tx_byte, 1) & 8'h7F), tx_byte[BTAIL_W-1:0]})))));

  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r6_result_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rx_valid));

  a_r7_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);
endmodule

bind pp_codec pp_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .parity_mode(parity_mode),
  .in_valid(in_valid), .in_ready(in_ready),
  .tx_valid(tx_valid), .tx_byte(tx_byte),
  .rx_valid(rx_valid), .out_valid(out_valid), .out_err(out_err)
);

// File: tb/tb_pp_codec.sv
module tb_pp_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       parity_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_a = '0, in_b = '0;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       out_valid;
  logic [9:0] out_a, out_b;
  logic       out_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pp_codec dut (
    .clk(clk), .rst_n(rst_n), .parity_mode(parity_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_err(out_err)
  );

  // {parity_mode, A, B}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 10'h000, 10'h000},
    {1'b0, 10'h3FF, 10'h3FF},
    {1'b1, 10'h3FF, 10'h001},
    {1'b1, 10'h2A5, 10'h15A},
    {1'b0, 10'h155, 10'h2AA},
    {1'b1, 10'h001, 10'h000}
  };

  function automatic logic [23:0] grp(input logic m, input logic [9:0] a, input logic [9:0] b);
    logic s;
    s = m & (^a ^ ^b);
    return {1'b1, a[9:3], 1'b0, a[2:0], b[9:6], 1'b0, s, b[5:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_none(input string req);
    chk(out_valid == 1'b0, req, 32'(out_valid), 32'h0);
  endtask

  task automatic expect_good(input string req, input logic [9:0] a, input logic [9:0] b);
    chk(out_valid && !out_err, req, {30'h0, out_valid, out_err}, 32'h2);
    chk(out_a == a, req, 32'(out_a), 32'(a));
    chk(out_b == b, req, 32'(out_b), 32'(b));
  endtask

  task automatic expect_err(input string req);
    chk(out_valid && out_err, req, {30'h0, out_valid, out_err}, 32'h3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] e, g1, g2;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(in_ready == 1'b1, "R10 in_ready", 32'(in_ready), 32'h1);
    chk(tx_valid == 1'b0, "R10 tx_valid", 32'(tx_valid), 32'h0);
    chk(out_valid == 1'b0, "R10 out_valid", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // vector table: encode, then loop bytes back into the decoder
    for (int i = 0; i < 6; i++) begin
      parity_mode = VEC[i][20];
      e = grp(VEC[i][20], VEC[i][19:10], VEC[i][9:0]);
      in_a = VEC[i][19:10];
      in_b = VEC[i][9:0];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(tx_valid && tx_byte == e[23:16], "R1 byte1", {23'h0, tx_valid, tx_byte}, {23'h1, e[23:16]});
      chk(in_ready == 1'b0, "R4 ready byte1", 32'(in_ready), 32'h0);
      @(negedge clk);
      chk(tx_valid && tx_byte == e[15:8], "R2 byte2", {23'h0, tx_valid, tx_byte}, {23'h1, e[15:8]});
      chk(in_ready == 1'b0, "R4 ready byte2", 32'(in_ready), 32'h0);
      @(negedge clk);
      chk(tx_valid && tx_byte == e[7:0], "R3 byte3", {23'h0, tx_valid, tx_byte}, {23'h1, e[7:0]});
      chk(in_ready == 1'b1, "R4 ready byte3", 32'(in_ready), 32'h1);
      @(negedge clk);
      chk(tx_valid == 1'b0, "R4 idle after group", 32'(tx_valid), 32'h0);
      push(e[23:16]); expect_none("R6 no pulse byte1");
      push(e[15:8]);  expect_none("R6 no pulse byte2");
      push(e[7:0]);   expect_good("R6 loopback", VEC[i][19:10], VEC[i][9:0]);
    end

    // R4 back-to-back pairs stream without a gap
    parity_mode = 1'b0;
    g1 = grp(1'b0, 10'h123, 10'h045);
    g2 = grp(1'b0, 10'h3A0, 10'h27F);
    in_a = 10'h123; in_b = 10'h045; in_valid = 1'b1;
    @(negedge clk);
    in_a = 10'h3A0; in_b = 10'h27F;
    chk(tx_byte == g1[23:16], "R4 stream g1 byte1", 32'(tx_byte), 32'(g1[23:16]));
    @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R4 ready overlaps byte3", 32'(in_ready), 32'h1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tx_valid && tx_byte == g2[23:16], "R4 stream g2 byte1", {23'h0, tx_valid, tx_byte}, {23'h1, g2[23:16]});
    repeat (3) @(negedge clk);

    // R5 hunting discards, R11 idle gaps ignored
    e = grp(1'b0, 10'h2A5, 10'h1C3);
    push(8'h12); expect_none("R5 drop 12");
    push(8'h7F); expect_none("R5 drop 7F");
    push(8'h00); expect_none("R5 drop 00");
    push(e[23:16]);
    rx_byte = 8'hC5; repeat (2) @(negedge clk); expect_none("R11 idle gap");
    push(e[15:8]);
    rx_byte = 8'h81; repeat (2) @(negedge clk); expect_none("R11 idle gap 2");
    push(e[7:0]); expect_good("R11 group with gaps", 10'h2A5, 10'h1C3);

    // R7 fixed mode with spare set
    e = grp(1'b0, 10'h0F0, 10'h30F);
    push(e[23:16]); push(e[15:8]); push(e[7:0] | 8'h40);
    expect_err("R7 spare set in fixed mode");

    // R8 parity mismatch
    parity_mode = 1'b1;
    e = grp(1'b1, 10'h2A5, 10'h1C3);
    push(e[23:16]); push(e[15:8]); push(e[7:0] ^ 8'h40);
    expect_err("R8 parity mismatch");
    push(e[23:16]); push(e[15:8]); push(e[7:0]);
    expect_good("R8 parity match", 10'h2A5, 10'h1C3);

    // R9 marker in position two, then in position three
    parity_mode = 1'b0;
    g1 = grp(1'b0, 10'h111, 10'h222);
    g2 = grp(1'b0, 10'h3C3, 10'h0AB);
    push(g1[23:16]); push(g2[23:16]); expect_err("R9 marker at byte2");
    push(g2[15:8]);  expect_none("R9 resync byte2");
    push(g2[7:0]);   expect_good("R9 resync from byte2", 10'h3C3, 10'h0AB);
    push(g1[23:16]); push(g1[15:8]); push(g2[23:16]); expect_err("R9 marker at byte3");
    push(g2[15:8]);  push(g2[7:0]);  expect_good("R9 resync from byte3", 10'h3C3, 10'h0AB);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule